// File: doc/BRIEF.md
# Integer ALU with Carry Flag

This block is the 32-bit integer execution unit of a small RISC core. Each cycle it takes a register operand A, a second operand that is either a register value or a sign-extended 16-bit immediate, and a 6-bit operation code from the decoder. It returns a 32-bit result combinationally. It also keeps the core's carry flag in a register, which changes only on a clock edge.

The arithmetic is an adder that either adds (A + B + cin) or subtracts in reverse (B - A, formed as B + ~A + cin). Per-operation modifiers choose two things: whether the stored flag feeds the carry-in, and whether the carry-out is written back. The compare operations reuse the reverse difference and correct its top bit so that it gives the true signed or unsigned ordering. Four bitwise operations complete the set. Multiply, shifts, instruction decode and register access are outside this block.

The operation code is split into fields. Bits [5:4] select the group: 00 arithmetic, 01 compare, 10 bitwise, 11 reserved. Bit 3 selects the immediate as operand B in every group. The meaning of bits [2:0] depends on the group (see R1 to R11).

Top module: `int_alu_cf`

## Requirements
- R1: Arithmetic group, bit 0 = 0: result = A + B + cin. With bit 1 = 0, cin is 0. With bit 1 = 1, cin is the stored carry flag.
- R2: Arithmetic group, bit 0 = 1: result = B + ~A + cin. With bit 1 = 0, cin is 1. With bit 1 = 1, cin is the stored carry flag.
- R3: An arithmetic operation with op_valid high and bit 2 = 0 loads the 32-bit adder's carry-out into carry_q on the next rising clock edge.
- R4: An arithmetic operation with bit 2 = 1 leaves carry_q unchanged.
- R5: Bit 3 = 1 replaces operand B with imm16 sign-extended to 32 bits. This applies to every group.
- R6: Compare group, bit 0 = 0 (signed): result = B + ~A + 1. When the MSBs of A and B differ, the result MSB is replaced by the MSB of B.
- R7: Compare group, bit 0 = 1 (unsigned): result = B + ~A + 1. When the MSBs of A and B differ, the result MSB is replaced by the MSB of A.
- R8: Bitwise group, bits [1:0] select the operation: 00 A|B, 01 A&B, 10 A^B, 11 A&~B. Bitwise operations never change carry_q.
- R9: Compare operations never change carry_q.
- R10: An active-low rst_n clears carry_q. While op_valid is low, carry_q does not change.
- R11: The reserved group (bits [5:4] = 11) gives a result of zero and never changes carry_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | The operation on the inputs is issued this cycle |
| op_code | input | 6 | Group and modifier bits |
| op_a | input | 32 | Register operand A |
| op_b | input | 32 | Register operand B |
| imm16 | input | 16 | Immediate field, sign-extended when bit 3 is set |
| result | output | 32 | Combinational result |
| carry_q | output | 1 | Stored carry flag |

## Verification
The bench targets the carry at the 32-bit boundary. It adds all-ones plus one and subtracts equal and larger values. A carry-out taken from the wrong bit, or a reverse subtract that inverts B instead of A, shows up there as a wrong result or a wrong flag. The flag is first set, then cleared, and then followed by keep-carry, compare, bitwise and idle cycles. A design that writes the flag in any of those cases is caught on the next edge. The compare cases use operand pairs whose MSBs differ, so a design that picks the MSB from the wrong operand reverses the ordering. Negative immediates expose a design that zero-extends instead of sign-extending.

// File: rtl/int_alu_cf_pkg.sv
package int_alu_cf_pkg;
  localparam int OPW = 6;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_CMP   = 2'b01,
    GRP_LOGIC = 2'b10,
    GRP_RSVD  = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    LG_OR   = 2'b00,
    LG_AND  = 2'b01,
    LG_XOR  = 2'b10,
    LG_ANDN = 2'b11
  } lsel_e;

  typedef struct packed {
    grp_e  grp;
    logic  use_imm;
    logic  keep_cf;
    logic  use_cf;
    logic  rev;
    lsel_e lsel;
  } dec_t;

  function automatic dec_t f_decode(input logic [OPW-1:0] op);
    dec_t d;
    d.grp     = grp_e'(op[5:4]);
    d.use_imm = op[3];
    d.keep_cf = op[2];
    d.use_cf  = op[1];
    d.rev     = op[0];
    d.lsel    = lsel_e'(op[1:0]);
    return d;
  endfunction
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [W-1:0]  reg_b,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  output logic [W-1:0]  b_eff
);
  localparam int EXT = W - IW;

  function automatic logic [W-1:0] f_sext(input logic [IW-1:0] v);
    return {{EXT{v[IW-1]}}, v};
  endfunction

  assign b_eff = use_imm ? f_sext(imm) : reg_b;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rev,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  function automatic logic [W:0] f_addc(input logic [W-1:0] x,
                                        input logic [W-1:0] y,
                                        input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W-1:0] a_term;
  logic [W:0]   full;

  assign a_term      = rev ? ~a : a;
  assign full        = f_addc(b, a_term, cin);
  assign {cout, sum} = full;
endmodule

// File: rtl/alu_cmp_fix.sv
module alu_cmp_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] diff,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic         uns,
  output logic [W-1:0] res
);
  logic sign_mix;
  logic fixed_msb;

  assign sign_mix  = a_msb ^ b_msb;
  assign fixed_msb = uns ? a_msb : b_msb;
  assign res       = sign_mix ? {fixed_msb, diff[W-2:0]} : diff;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  int_alu_cf_pkg::lsel_e sel,
  output logic [W-1:0]         res
);
  import int_alu_cf_pkg::*;

  always_comb begin
    unique case (sel)
      LG_OR:   res = a | b;
      LG_AND:  res = a & b;
      LG_XOR:  res = a ^ b;
      default: res = a & ~b;
    endcase
  end
endmodule

// File: rtl/int_alu_cf.sv
module int_alu_cf
  import int_alu_cf_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [IW-1:0]  imm16,
  output logic [W-1:0]   result,
  output logic           carry_q
);
  dec_t         dec;
  logic [W-1:0] b_eff;
  logic         add_rev;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] cmp_res;
  logic [W-1:0] lg_res;
  logic         is_cmp;
  logic         flag_we;

  assign dec    = f_decode(op_code);
  assign is_cmp = (dec.grp == GRP_CMP);

  alu_opnd_sel #(.W(W), .IW(IW)) u_sel (
    .reg_b   (op_b),
    .imm     (imm16),
    .use_imm (dec.use_imm),
    .b_eff   (b_eff)
  );

  // compare always forms B + ~A + 1; arithmetic honours its modifiers
  assign add_rev = is_cmp ? 1'b1 : dec.rev;
  assign add_cin = is_cmp ? 1'b1 : (dec.use_cf ? carry_q : dec.rev);

  alu_addsub #(.W(W)) u_add (
    .a    (op_a),
    .b    (b_eff),
    .rev  (add_rev),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  alu_cmp_fix #(.W(W)) u_cmp (
    .diff  (add_sum),
    .a_msb (op_a[W-1]),
    .b_msb (b_eff[W-1]),
    .uns   (dec.rev),
    .res   (cmp_res)
  );

  alu_logic #(.W(W)) u_lg (
    .a   (op_a),
    .b   (b_eff),
    .sel (dec.lsel),
    .res (lg_res)
  );

  always_comb begin
    unique case (dec.grp)
      GRP_ARITH: result = add_sum;
      GRP_CMP:   result = cmp_res;
      GRP_LOGIC: result = lg_res;
      default:   result = '0;
    endcase
  end

  assign flag_we = op_valid && (dec.grp == GRP_ARITH) && !dec.keep_cf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       carry_q <= 1'b0;
    else if (flag_we) carry_q <= add_cout;
  end
endmodule

// File: rtl/int_alu_cf_chk.sv
module int_alu_cf_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [5:0]   op_code,
  input logic [W-1:0] op_a,
  input logic [W-1:0] b_eff,
  input logic [W-1:0] result,
  input logic         add_cout,
  input logic         carry_q
);
  p_carry_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[5:4] == 2'b00 && !op_code[2]) |=> carry_q == $past(add_cout));

  p_keep_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[5:4] == 2'b00 && op_code[2]) |=> $stable(carry_q));

  p_signed_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code[5:4] == 2'b01 && !op_code[0] && (op_a[W-1] != b_eff[W-1]))
      |-> result[W-1] == b_eff[W-1]);

  p_unsigned_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code[5:4] == 2'b01 && op_code[0] && (op_a[W-1] != b_eff[W-1]))
      |-> result[W-1] == op_a[W-1]);

  p_logic_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[5:4] == 2'b10) |=> $stable(carry_q));

  p_cmp_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[5:4] == 2'b01) |=> $stable(carry_q));

  p_idle_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(carry_q));

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code[5:4] == 2'b11) |-> result == '0);
endmodule

bind int_alu_cf int_alu_cf_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_a     (op_a),
  .b_eff    (b_eff),
  .result   (result),
  .add_cout (add_cout),
  .carry_q  (carry_q)
);

// File: tb/int_alu_cf_tb_top.sv
module int_alu_cf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [5:0]  op_code = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] result;
  logic        carry_q;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic exp_cf = 1'b0;

  always #5 clk = ~clk;

  int_alu_cf dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .imm16(imm16), .result(result), .carry_q(carry_q)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s carry act=%b exp=%b", tag, act, exp);
    end
  endtask

  // independent reference: returns {write_flag, new_flag, result}
  function automatic logic [33:0] model(logic [5:0] op, logic [31:0] a,
                                        logic [31:0] rb, logic [15:0] im, logic cf);
    logic [31:0] b;
    logic [32:0] wide;
    logic [31:0] r;
    logic        cin;
    b = op[3] ? {{16{im[15]}}, im} : rb;
    case (op[5:4])
      2'b00: begin
        cin = op[1] ? cf : op[0];
        if (op[0]) wide = {1'b0, b} + {1'b0, ~a} + 33'(cin);
        else       wide = {1'b0, a} + {1'b0, b} + 33'(cin);
        return {!op[2], wide[32], wide[31:0]};
      end
      2'b01: begin
        r = b - a;
        if (a[31] != b[31]) r[31] = op[0] ? a[31] : b[31];
        return {1'b0, cf, r};
      end
      2'b10: begin
        case (op[1:0])
          2'b00: r = a | b;
          2'b01: r = a & b;
          2'b10: r = a ^ b;
          default: r = a & ~b;
        endcase
        return {1'b0, cf, r};
      end
      default: return {1'b0, cf, 32'h0};
    endcase
  endfunction

  task automatic run_op(string tag, logic [5:0] op, logic [31:0] a,
                        logic [31:0] b, logic [15:0] im, logic v = 1'b1);
    logic [33:0] m;
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; imm16 = im; op_valid = v;
    m = model(op, a, b, im, exp_cf);
    #2;
    check32(tag, result, m[31:0]);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    if (v && m[33]) exp_cf = m[32];
    check1(tag, carry_q, exp_cf);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    exp_cf = 1'b0;
    check1("R10 reset", carry_q, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    run_op("R1 R3 add wrap", 6'b000000, 32'hFFFF_FFFF, 32'h1, 16'h0);
    run_op("R1 R3 add small", 6'b000000, 32'd5, 32'd7, 16'h0);
    run_op("R1 add msb", 6'b000000, 32'h8000_0000, 32'h8000_0000, 16'h0);
  endtask

  task automatic t_rsub();
    run_op("R2 rsub pos", 6'b000001, 32'd3, 32'd10, 16'h0);
    run_op("R2 rsub borrow", 6'b000001, 32'd10, 32'd3, 16'h0);
    run_op("R2 rsub equal", 6'b000001, 32'h1234_5678, 32'h1234_5678, 16'h0);
  endtask

  task automatic t_carry_in();
    run_op("R1 set cf", 6'b000000, 32'hFFFF_FFFF, 32'h2, 16'h0);
    run_op("R1 addc cf1", 6'b000010, 32'd1, 32'd1, 16'h0);
    run_op("R2 rsubc cf0", 6'b000011, 32'd5, 32'd5, 16'h0);
    run_op("R2 rsubc after", 6'b000011, 32'd5, 32'd9, 16'h0);
    run_op("R1 addc wrap", 6'b000010, 32'hFFFF_FFFF, 32'h0, 16'h0);
  endtask

  task automatic t_keep();
    run_op("R3 set", 6'b000000, 32'hFFFF_FFFF, 32'h1, 16'h0);
    run_op("R4 addk", 6'b000100, 32'd1, 32'd1, 16'h0);
    run_op("R4 rsubk", 6'b000101, 32'd9, 32'd2, 16'h0);
    run_op("R3 clear", 6'b000000, 32'd1, 32'd1, 16'h0);
    run_op("R4 addk wrap", 6'b000100, 32'hFFFF_FFFF, 32'h1, 16'h0);
    run_op("R4 addkc", 6'b000110, 32'd4, 32'd4, 16'h0);
  endtask

  task automatic t_imm();
    run_op("R5 addi neg", 6'b001000, 32'd10, 32'hDEAD_BEEF, 16'hFFFF);
    run_op("R5 rsubi", 6'b001001, 32'd1, 32'h0, 16'h8000);
    run_op("R5 addi pos", 6'b001000, 32'd10, 32'h0, 16'h7FFF);
    run_op("R5 R8 andi neg", 6'b101001, 32'hF0F0_1234, 32'h0, 16'hFF00);
  endtask

  task automatic t_cmp();
    run_op("R3 set", 6'b000000, 32'hFFFF_FFFF, 32'h1, 16'h0);
    run_op("R6 R9 s mix", 6'b010000, 32'd1, 32'hFFFF_FFFF, 16'h0);
    run_op("R6 s mix2", 6'b010000, 32'h8000_0000, 32'd5, 16'h0);
    run_op("R6 s same", 6'b010000, 32'd3, 32'd9, 16'h0);
    run_op("R7 R9 u mix", 6'b010001, 32'd1, 32'hFFFF_FFFF, 16'h0);
    run_op("R7 u mix2", 6'b010001, 32'h8000_0000, 32'd5, 16'h0);
    run_op("R7 u same", 6'b010001, 32'd9, 32'd3, 16'h0);
    run_op("R5 R6 cmpi", 6'b011000, 32'd2, 32'h0, 16'hFFFE);
  endtask

  task automatic t_logic();
    run_op("R8 or", 6'b100000, 32'hF0F0_0000, 32'h0F00_00FF, 16'h0);
    run_op("R8 and", 6'b100001, 32'hFFFF_0000, 32'h0FF0_0FF0, 16'h0);
    run_op("R8 xor", 6'b100010, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0);
    run_op("R8 andn", 6'b100011, 32'hFFFF_FFFF, 32'h0000_F00F, 16'h0);
    run_op("R8 ori", 6'b101000, 32'h0000_0001, 32'h0, 16'h8000);
  endtask

  task automatic t_idle_rsvd();
    run_op("R3 clear", 6'b000000, 32'd0, 32'd0, 16'h0);
    run_op("R10 idle", 6'b000000, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0);
    run_op("R11 rsvd", 6'b110000, 32'hFFFF_FFFF, 32'h1, 16'h0);
    run_op("R11 rsvd imm", 6'b111111, 32'h1234, 32'h1, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_add();
    t_rsub();
    t_carry_in();
    t_keep();
    t_imm();
    t_cmp();
    t_logic();
    t_idle_rsvd();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule